// File: doc/BRIEF.md
# Quad CIF Channel Multiplexer

This block packs four independent 352x288 video channels into one 1440-byte by 576-line active picture, giving each channel one quadrant of 360x288 pixels. A timing generator presents a request with an active line number and an active byte position. The block works out which quadrant holds that position and fetches the next byte from that channel's line-buffered source, which already supplies bytes in Cb, Y, Cr, Y order. It returns the byte one clock later.

A channel is 704 bytes wide and its quadrant is 720 bytes wide, so each quadrant has a 16-byte margin on its right. The block fills that margin with the neutral pair 0x80, 0x10. It uses the same fill when a position lies outside the active picture, and when the owning channel has no byte ready. A channel that misses a byte raises its underrun flag. The flag stays set until reset.

Top module: `quad_cif_mux`

## Requirements
- R1: After reset, `outValid` is 0 and `underrun` is 4'b0000. A reset also clears any underrun flag that was set earlier.
- R2: `outValid` equals the `reqValid` of the previous cycle. `outData` holds the answer to the request sampled at the previous rising edge.
- R3: The channel for a position is 2*(line >= 288) + (byte >= 720). Channel 0 is top-left, 1 is top-right, 2 is bottom-left and 3 is bottom-right. Channel k uses bits [8k+7:8k] of `srcData` and bit k of `srcReady`, `srcTake` and `underrun`.
- R4: A request is in a channel's region when its offset within the quadrant (byte, or byte-720 for the right-hand quadrants) is 0..703. If that channel is ready, `srcTake` bit k is high in the same cycle as the request, and the channel's byte appears on `outData` one cycle later.
- R5: When the quadrant offset is 704..719, the output is 0x80 for an even byte position and 0x10 for an odd one. No `srcTake` bit is raised and no underrun flag changes.
- R6: When a request falls in a channel's region and that channel's `srcReady` is 0, the output is the fill byte of R5 (chosen by byte parity), no `srcTake` bit is raised, and `underrun[k]` becomes 1. The flag stays 1 until reset.
- R7: When line >= 576 or byte >= 1440, the output is the R5 fill byte, no `srcTake` bit is raised and no underrun flag changes.
- R8: At most one `srcTake` bit is high, and only while `reqValid` is high.
- R9: While `reqValid` is 0, no source is popped and no underrun flag changes, whatever `srcReady` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Byte request strobe from the timing generator |
| reqLine | input | 10 | Active line of the request, 0..575 |
| reqByte | input | 11 | Active byte position of the request, 0..1439 |
| srcReady | input | 4 | Per-channel flag: the next byte is available |
| srcData | input | 32 | Next byte of each channel, channel k in bits [8k+7:8k] |
| srcTake | output | 4 | Per-channel pop strobe, combinational from the request |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Muxed byte, registered |
| underrun | output | 4 | Sticky per-channel underrun flags |

## Verification
The assertions assume that `srcReady` and `srcData` are stable from the start of a request cycle until the rising edge that ends it. They also assume that a source's byte belongs to the cycle in which its `srcTake` bit is high. The bench meets these assumptions by driving every input on the falling edge and holding it across the next rising edge. It gives each channel a distinct constant byte (0x11, 0x22, 0x33, 0x44) that differs from both fill values, so a wrong channel or a fill byte shows up at once. The stimulus also includes positions outside the picture and ready masks that starve one channel at a time, which the assertions must tolerate.

// File: rtl/quadmux_pkg.sv
package quadmux_pkg;
  // Strobes from position decode to the byte datapath
  typedef struct packed {
    logic       chanReq;  // request lies inside a channel's 704-byte region
    logic [1:0] chan;     // quadrant index
    logic       oddByte;  // parity of the byte position, selects the fill byte
  } quadCtrl_t;

  localparam logic [7:0] FILL_EVEN = 8'h80;
  localparam logic [7:0] FILL_ODD  = 8'h10;
  localparam int         NUM_CH    = 4;
endpackage

// File: rtl/quadmux_ctrl.sv
module quadmux_ctrl
  import quadmux_pkg::*;
#(
  parameter int CH_BYTES   = 704,
  parameter int SLOT_BYTES = 720,
  parameter int ROWS       = 288,
  parameter int LINE_W     = 10,
  parameter int BYTE_W     = 11
) (
  input  logic              reqValid,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [BYTE_W-1:0] reqByte,
  output quadCtrl_t         ctrl
);
  localparam logic [BYTE_W-1:0] SLOT_B  = BYTE_W'(SLOT_BYTES);
  localparam logic [BYTE_W-1:0] WIDE_B  = BYTE_W'(2 * SLOT_BYTES);
  localparam logic [BYTE_W-1:0] CH_B    = BYTE_W'(CH_BYTES);
  localparam logic [LINE_W-1:0] ROWS_L  = LINE_W'(ROWS);
  localparam logic [LINE_W-1:0] TALL_L  = LINE_W'(2 * ROWS);

  logic              rightHalf, lowerHalf, inPicture;
  logic [BYTE_W-1:0] slotOffset;

  always_comb begin
    rightHalf    = reqByte >= SLOT_B;
    lowerHalf    = reqLine >= ROWS_L;
    inPicture    = (reqByte < WIDE_B) && (reqLine < TALL_L);
    slotOffset   = rightHalf ? reqByte - SLOT_B : reqByte;
    ctrl.chanReq = reqValid && inPicture && (slotOffset < CH_B);
    ctrl.chan    = {lowerHalf, rightHalf};
    ctrl.oddByte = reqByte[0];
  end
endmodule

// File: rtl/quadmux_dp.sv
module quadmux_dp
  import quadmux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  quadCtrl_t                ctrl,
  input  logic [NUM_CH-1:0]        srcReady,
  input  logic [NUM_CH*DATA_W-1:0] srcData,
  output logic [NUM_CH-1:0]        srcTake,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  output logic [NUM_CH-1:0]        underrun
);
  logic [DATA_W-1:0] fillByte, chanByte;
  logic              chanHit;

  always_comb begin
    fillByte = ctrl.oddByte ? DATA_W'(FILL_ODD) : DATA_W'(FILL_EVEN);
    chanByte = srcData[ctrl.chan*DATA_W +: DATA_W];
    chanHit  = ctrl.chanReq && srcReady[ctrl.chan];
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    logic selK;
    assign selK       = ctrl.chanReq && (ctrl.chan == 2'(k));
    assign srcTake[k] = selK && srcReady[k];

    always_ff @(posedge clk) begin
      if (!rstN)                    underrun[k] <= 1'b0;
      else if (selK && !srcReady[k]) underrun[k] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= reqValid;
      outData  <= chanHit ? chanByte : fillByte;
    end
  end
endmodule

// File: rtl/quad_cif_mux.sv
module quad_cif_mux
  import quadmux_pkg::*;
#(
  parameter  int CH_PIXELS   = 352,
  parameter  int SLOT_PIXELS = 360,
  parameter  int ROWS        = 288,
  parameter  int DATA_W      = 8,
  localparam int CH_BYTES    = 2 * CH_PIXELS,
  localparam int SLOT_BYTES  = 2 * SLOT_PIXELS,
  localparam int LINE_W      = $clog2(2 * ROWS + 1),
  localparam int BYTE_W      = $clog2(2 * SLOT_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [LINE_W-1:0]        reqLine,
  input  logic [BYTE_W-1:0]        reqByte,
  input  logic [3:0]               srcReady,
  input  logic [4*DATA_W-1:0]      srcData,
  output logic [3:0]               srcTake,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  output logic [3:0]               underrun
);
  quadCtrl_t ctrl;

  quadmux_ctrl #(
    .CH_BYTES(CH_BYTES), .SLOT_BYTES(SLOT_BYTES), .ROWS(ROWS),
    .LINE_W(LINE_W), .BYTE_W(BYTE_W)
  ) u_ctrl (
    .reqValid(reqValid), .reqLine(reqLine), .reqByte(reqByte), .ctrl(ctrl)
  );

  quadmux_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ctrl(ctrl),
    .srcReady(srcReady), .srcData(srcData), .srcTake(srcTake),
    .outValid(outValid), .outData(outData), .underrun(underrun)
  );
endmodule

// File: rtl/quad_cif_mux_chk.sv
module quad_cif_mux_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [3:0]        srcReady,
  input logic [3:0]        srcTake,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic [3:0]        underrun
);
  // R8: one pop at most, never without a request
  a_r8_take_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcTake) && (reqValid || srcTake == 4'b0000));

  // R4/R6: a pop only from a ready source
  a_r4_take_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    (srcTake & ~srcReady) == 4'b0000);

  // R2: one cycle of latency on the valid strobe
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(reqValid)));

  // R6: underrun flags never drop outside reset
  a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((underrun & $past(underrun)) == $past(underrun)));

  // R9: no flag rises without a request
  a_r9_idle_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (underrun == $past(underrun)));

  // R5/R7: a request with no pop yields a fill byte
  a_r5_fill_without_pop: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && srcTake == 4'b0000) |=>
      (outData == DATA_W'(8'h80) || outData == DATA_W'(8'h10)));
endmodule

bind quad_cif_mux quad_cif_mux_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .srcReady(srcReady),
  .srcTake(srcTake), .outValid(outValid), .outData(outData),
  .underrun(underrun)
);

// File: tb/quad_cif_mux_test.sv
module quad_cif_mux_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [9:0]  reqLine = '0;
  logic [10:0] reqByte = '0;
  logic [3:0]  srcReady = '0;
  logic [31:0] srcData = 32'h44332211;
  logic [3:0]  srcTake;
  logic        outValid;
  logic [7:0]  outData;
  logic [3:0]  underrun;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  quad_cif_mux uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine),
    .reqByte(reqByte), .srcReady(srcReady), .srcData(srcData),
    .srcTake(srcTake), .outValid(outValid), .outData(outData),
    .underrun(underrun)
  );

  // {line, byte, ready, expTake, expData, expUnderrun}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {10'd0,   11'd0,    4'hF, 4'b0001, 8'h11, 4'b0000},
    {10'd0,   11'd703,  4'hF, 4'b0001, 8'h11, 4'b0000},
    {10'd0,   11'd704,  4'hF, 4'b0000, 8'h80, 4'b0000},
    {10'd0,   11'd719,  4'hF, 4'b0000, 8'h10, 4'b0000},
    {10'd0,   11'd720,  4'hF, 4'b0010, 8'h22, 4'b0000},
    {10'd287, 11'd1423, 4'hF, 4'b0010, 8'h22, 4'b0000},
    {10'd287, 11'd1424, 4'hF, 4'b0000, 8'h80, 4'b0000},
    {10'd288, 11'd0,    4'hF, 4'b0100, 8'h33, 4'b0000},
    {10'd575, 11'd720,  4'hF, 4'b1000, 8'h44, 4'b0000},
    {10'd575, 11'd1439, 4'hF, 4'b0000, 8'h10, 4'b0000},
    {10'd576, 11'd0,    4'hF, 4'b0000, 8'h80, 4'b0000},
    {10'd0,   11'd1440, 4'hF, 4'b0000, 8'h80, 4'b0000},
    {10'd100, 11'd5,    4'hE, 4'b0000, 8'h10, 4'b0001},
    {10'd300, 11'd900,  4'h7, 4'b0000, 8'h80, 4'b1001},
    {10'd300, 11'd710,  4'h0, 4'b0000, 8'h80, 4'b1001},
    {10'd10,  11'd10,   4'hF, 4'b0001, 8'h11, 4'b1001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, check the pop before the rising edge, result after it
  task automatic request(input logic [9:0] ln, input logic [10:0] bt, input logic [3:0] rdy,
                         input logic [3:0] expTake, input logic [7:0] expData,
                         input logic [3:0] expUnder, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqLine = ln; reqByte = bt; srcReady = rdy;
    #1;
    check({tag, " R3/R8 srcTake"}, 32'(srcTake), 32'(expTake));
    @(negedge clk);
    check({tag, " R2 outValid"}, 32'(outValid), 32'd1);
    check({tag, " outData"}, 32'(outData), 32'(expData));
    check({tag, " underrun"}, 32'(underrun), 32'(expUnder));
    reqValid = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid after reset", 32'(outValid), 32'd0);
    check("R1 underrun after reset", 32'(underrun), 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (VEC[i][15:12] != 4'b0000) tag = $sformatf("R4 vec%0d", i);
      else if (VEC[i][3:0] != (i > 0 ? VEC[i-1][3:0] : 4'b0000)) tag = $sformatf("R6 vec%0d", i);
      else if (VEC[i][40:31] >= 10'd576 || VEC[i][30:20] >= 11'd1440) tag = $sformatf("R7 vec%0d", i);
      else tag = $sformatf("R5 vec%0d", i);
      request(VEC[i][40:31], VEC[i][30:20], VEC[i][19:16], VEC[i][15:12],
              VEC[i][11:4], VEC[i][3:0], tag);
    end

    // R9: idle cycle with a starved channel region on the bus
    @(negedge clk);
    reqValid = 1'b0; reqLine = 10'd0; reqByte = 11'd0; srcReady = 4'h0;
    #1;
    check("R9 no pop while idle", 32'(srcTake), 32'd0);
    @(negedge clk);
    check("R2 outValid low after idle", 32'(outValid), 32'd0);
    check("R9 underrun unchanged while idle", 32'(underrun), 32'b1001);

    // R6: channel 1 starved in the lower-right corner of its region
    request(10'd287, 11'd1423, 4'hD, 4'b0000, 8'h10, 4'b1011, "R6 ch1 starved");
    // R3: bottom-left last channel byte
    request(10'd575, 11'd703, 4'hF, 4'b0100, 8'h33, 4'b1011, "R3 ch2 edge");

    // R1: reset clears sticky flags
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 underrun cleared by reset", 32'(underrun), 32'd0);
    check("R1 outValid cleared by reset", 32'(outValid), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule